// File: doc/BRIEF.md
# Gate Charge-Pump Refresh Scheduler

This block decides when the gate charge pump of a hot-swap switch runs while the switch is fully on. Between bursts the pump sleeps and the gate capacitance holds the gate up by itself. A burst starts when a comparator reports that the gate has drooped too far below its high level. A burst also starts when a refresh interval, counted in timebase ticks, runs out. The burst ends as soon as a second comparator reports that the gate is back at its target.

The refresh interval restarts every time the pump turns on, whichever trigger caused it. It stays cleared for the length of a burst and counts again from zero once the pump sleeps. A burst that never reaches the target is cut off after a bounded number of clock cycles, and a sticky error flag is raised. Outside the normal-on state the pump is held off, the interval is cleared and the error flag is cleared.

Top module: `gcp_refresh_sched`

## Requirements
- R1: While sleeping in normal-on mode, with no droop flag and no expiring refresh tick, the pump enable stays low.
- R2: With normal-on high and the pump asleep, a high droop flag raises the pump enable on the next clock cycle.
- R3: With no droop, the pump enable rises one cycle after the REFRESH_TICKS-th tick counted since the pump last turned off (or since normal-on rose), whatever the spacing of the ticks.
- R4: A droop-triggered burst restarts the refresh interval, so the next refresh burst needs a full REFRESH_TICKS ticks after that burst ends.
- R5: While pumping, a high at-target flag drops the pump enable on the next cycle, and it wins over a burst timeout falling in that same cycle (no error is raised).
- R6: While normal-on is low, the pump enable is low one cycle later, droop flags and ticks are ignored, and the refresh interval is cleared.
- R7: A burst that never sees the at-target flag keeps the pump enabled for exactly MAX_BURST cycles, then drops it and raises the error flag in the same cycle.
- R8: The error flag stays high while normal-on stays high, through later bursts, and is cleared one cycle after normal-on goes low.
- R9: After reset the pump enable and the error flag are low and the refresh interval starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase tick for the refresh interval |
| norm_on_i | input | 1 | Switch is in its normal-on state |
| droop_i | input | 1 | Gate has drooped below the restart threshold |
| at_target_i | input | 1 | Gate is back at its high target |
| pump_en_o | output | 1 | Charge pump enable |
| burst_err_o | output | 1 | Sticky flag: a burst timed out without reaching target |

## Verification
The bench sweeps the spacing between ticks to catch a refresh that fires one tick early or late, and a design that counts clock cycles instead of ticks. It starts a droop burst in the middle of an interval: a design that keeps the old schedule fires the refresh too soon. It ends a burst with the at-target flag on the very cycle the timeout would fire, so a wrong priority shows up as a false error. It also drops normal-on partway through an interval, so a timer that is not cleared shows up as an early refresh after re-enable.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    typedef enum logic {
        PS_SLEEP = 1'b0,
        PS_PUMP  = 1'b1
    } pump_state_e;

    typedef struct packed {
        logic droop;
        logic refresh;
    } trig_t;

    function automatic logic any_trig(input trig_t t);
        return t.droop | t.refresh;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/gcp_refresh_timer.sv
module gcp_refresh_timer #(
    parameter int unsigned LIMIT = 15
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int unsigned W = gcp_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign expire_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gcp_burst_timer.sv
module gcp_burst_timer #(
    parameter int unsigned LIMIT = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned W = gcp_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gcp_pump_fsm.sv
module gcp_pump_fsm (
    input  logic clk_i,
    input  logic rst_i,
    input  logic norm_on_i,
    input  logic droop_i,
    input  logic refresh_exp_i,
    input  logic at_target_i,
    input  logic burst_exp_i,
    output logic start_o,
    output logic pump_on_o,
    output logic err_o
);
    import gcp_pkg::*;

    pump_state_e state_q, state_d;
    trig_t       trig;
    logic        err_q;
    logic        timeout;

    always_comb begin
        trig.droop   = droop_i;
        trig.refresh = refresh_exp_i;
    end

    assign start_o   = (state_q == PS_SLEEP) && norm_on_i && any_trig(trig);
    assign timeout   = (state_q == PS_PUMP) && !at_target_i && burst_exp_i;
    assign pump_on_o = (state_q == PS_PUMP);
    assign err_o     = err_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PS_SLEEP: if (start_o) state_d = PS_PUMP;
            PS_PUMP: begin
                if (!norm_on_i || at_target_i || burst_exp_i) state_d = PS_SLEEP;
            end
            default: state_d = PS_SLEEP;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PS_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !norm_on_i) begin
            err_q <= 1'b0;
        end else if (timeout) begin
            err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/gcp_refresh_sched.sv
module gcp_refresh_sched #(
    parameter int unsigned REFRESH_TICKS = 15,
    parameter int unsigned MAX_BURST     = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic norm_on_i,
    input  logic droop_i,
    input  logic at_target_i,
    output logic pump_en_o,
    output logic burst_err_o
);
    logic start;
    logic pump_on;
    logic refresh_exp;
    logic burst_exp;
    logic refresh_clr;

    assign refresh_clr = !norm_on_i || pump_on || start;

    gcp_refresh_timer #(.LIMIT(REFRESH_TICKS)) refresh_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (refresh_clr),
        .tick_i  (tick_i),
        .expire_o(refresh_exp)
    );

    gcp_burst_timer #(.LIMIT(MAX_BURST)) burst_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (pump_on),
        .expire_o(burst_exp)
    );

    gcp_pump_fsm fsm_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .norm_on_i    (norm_on_i),
        .droop_i      (droop_i),
        .refresh_exp_i(refresh_exp),
        .at_target_i  (at_target_i),
        .burst_exp_i  (burst_exp),
        .start_o      (start),
        .pump_on_o    (pump_on),
        .err_o        (burst_err_o)
    );

    assign pump_en_o = pump_on;
endmodule

// File: rtl/gcp_refresh_sched_chk.sv
module gcp_refresh_sched_chk #(
    parameter int unsigned MAX_BURST = 32
) (
    input logic clk_i,
    input logic rst_i,
    input logic tick_i,
    input logic norm_on_i,
    input logic droop_i,
    input logic at_target_i,
    input logic pump_en_o,
    input logic burst_err_o
);
    localparam int unsigned RW = $clog2(MAX_BURST + 2);
    localparam logic [RW-1:0] RMAX = RW'(MAX_BURST);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !pump_en_o) begin
            run_q <= '0;
        end else if (run_q <= RMAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    a_r1_sleep_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pump_en_o && !droop_i && !tick_i) |=> !pump_en_o);

    a_r2_droop_starts: assert property (@(posedge clk_i) disable iff (rst_i)
        (norm_on_i && droop_i && !pump_en_o) |=> pump_en_o);

    a_r5_target_stops: assert property (@(posedge clk_i) disable iff (rst_i)
        (pump_en_o && at_target_i) |=> (!pump_en_o && $stable(burst_err_o)));

    a_r6_off_when_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        !norm_on_i |=> !pump_en_o);

    a_r7_burst_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q <= RMAX);

    a_r7_err_with_stop: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(burst_err_o) |-> (!pump_en_o && $past(pump_en_o)));

    a_r8_err_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        !norm_on_i |=> !burst_err_o);
endmodule

bind gcp_refresh_sched gcp_refresh_sched_chk #(.MAX_BURST(MAX_BURST)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .norm_on_i  (norm_on_i),
    .droop_i    (droop_i),
    .at_target_i(at_target_i),
    .pump_en_o  (pump_en_o),
    .burst_err_o(burst_err_o)
);

// File: tb/gcp_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module gcp_refresh_sched_tb_top;
    localparam int RT = 4;
    localparam int MB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic norm_on = 1'b0;
    logic droop = 1'b0;
    logic at_target = 1'b0;
    logic pump_en;
    logic burst_err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gcp_refresh_sched #(.REFRESH_TICKS(RT), .MAX_BURST(MB)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_i     (tick),
        .norm_on_i  (norm_on),
        .droop_i    (droop),
        .at_target_i(at_target),
        .pump_en_o  (pump_en),
        .burst_err_o(burst_err)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // n ticks spaced by gap idle cycles; pump expected on right after tick number fire_at
    task automatic ticks(input int n, input int gap, input int fire_at, input string req);
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            cyc();
            tick = 1'b0;
            chk(req, pump_en, i == fire_at);
            if (i == fire_at) return;
            for (int g = 0; g < gap; g++) begin
                cyc();
                chk(req, pump_en, 1'b0);
            end
        end
    endtask

    task automatic end_burst();
        at_target = 1'b1;
        cyc();
        at_target = 1'b0;
        chk("R5", pump_en, 1'b0);
    endtask

    task automatic droop_pulse(input string req);
        droop = 1'b1;
        cyc();
        droop = 1'b0;
        chk(req, pump_en, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R9", pump_en, 1'b0);
        chk("R9", burst_err, 1'b0);

        // R6: disabled, droop and ticks ignored
        droop = 1'b1;
        for (int k = 0; k < 10; k++) begin
            tick = k[0];
            cyc();
            chk("R6", pump_en, 1'b0);
        end
        tick = 1'b0;
        droop = 1'b0;

        // R3 / R9: refresh after RT ticks, sweep tick spacing
        norm_on = 1'b1;
        for (int gap = 0; gap < 4; gap++) begin
            ticks(RT, gap, RT, "R3");
            end_burst();
        end

        // R1: no triggers, pump stays asleep
        for (int k = 0; k < 12; k++) begin
            cyc();
            chk("R1", pump_en, 1'b0);
        end

        // R4: droop mid-interval restarts the schedule
        ticks(2, 1, 0, "R4");
        droop_pulse("R2");
        end_burst();
        ticks(RT, 1, RT, "R4");
        end_burst();

        // R6: dropping normal-on clears the partial interval
        ticks(RT - 1, 0, 0, "R6");
        norm_on = 1'b0;
        cyc();
        norm_on = 1'b1;
        ticks(RT, 0, RT, "R6");
        end_burst();

        // R5: target on the cycle the timeout would fire wins
        droop_pulse("R2");
        for (int k = 1; k < MB; k++) cyc();
        chk("R5", pump_en, 1'b1);
        end_burst();
        chk("R5", burst_err, 1'b0);

        // R7: timeout after exactly MB cycles
        droop_pulse("R7");
        for (int k = 1; k <= MB; k++) begin
            chk("R7", pump_en, 1'b1);
            chk("R7", burst_err, 1'b0);
            cyc();
        end
        chk("R7", pump_en, 1'b0);
        chk("R7", burst_err, 1'b1);

        // R8: sticky through later burst, cleared by normal-on low
        repeat (3) cyc();
        chk("R8", burst_err, 1'b1);
        droop_pulse("R2");
        end_burst();
        chk("R8", burst_err, 1'b1);
        norm_on = 1'b0;
        cyc();
        chk("R8", burst_err, 1'b0);
        norm_on = 1'b1;

        // R6: normal-on lost mid burst
        droop_pulse("R2");
        cyc();
        norm_on = 1'b0;
        cyc();
        chk("R6", pump_en, 1'b0);
        chk("R8", burst_err, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule